// File: doc/BRIEF.md
# Fractional Baud Generator with Selectable Oversampling

This block makes the two timing strobes a UART needs: a sample strobe at the oversampling rate and a bit strobe at the bit rate. The sample period is set by a 16-bit integer divisor, assembled from two byte registers, plus a fraction in sixteenths of a clock. A 4-bit phase accumulator gains the fraction once per sample period. Whenever it wraps, that period runs one clock longer. Over sixteen periods the average length therefore equals the integer plus the fraction.

A third register holds the fraction and a 2-bit oversampling field. The field sets how many sample strobes make one bit: 16, 8 or 4. This register only accepts writes while the enhanced-feature enable input is high. Divisor values, the fraction and the mode are loaded into the counter only at the boundary between sample periods, so a period that has already started is never cut short or lengthened.

The period counter is a three-state machine:
- IDLE: the divisor is zero.
- COUNT: the integer part of the period.
- STRETCH: the one extra clock added after an accumulator carry.

Transitions:
- IDLE to COUNT when a non-zero divisor is present.
- COUNT to STRETCH at the end of the count when the period carries.
- COUNT to COUNT, or STRETCH to COUNT, at a boundary that reloads a non-zero divisor.
- COUNT to IDLE, or STRETCH to IDLE, at a boundary that finds the divisor zero. This also clears the accumulator and the bit counter.

Top module: `frac_baud_gen`

## Requirements
- R1: The register write port uses address 0 for the divisor low byte, address 1 for the divisor high byte and address 2 for the fraction/mode register. The integer divisor is {high byte, low byte}. With a fraction of 0, sample strobes are exactly that many clocks apart.
- R2: With fraction F (bits [3:0] of address 2) and a non-zero divisor D, every sample period is D or D+1 clocks long. Any 16 consecutive periods span exactly 16*D+F clocks.
- R3: Bits [5:4] of address 2 set the sample strobes per bit strobe: 00 gives 16, 01 gives 8, 10 and 11 give 4. The bit strobe is high only in a cycle where the sample strobe is also high.
- R4: A write to address 2 while the enhanced-feature enable is low leaves the fraction and the mode unchanged.
- R5: Bits [7:6] written to address 2 have no effect on either strobe.
- R6: After reset both strobes are low and stay low. A divisor of 0 stops both strobes, and a later non-zero divisor restarts them with the accumulator cleared.
- R7: A new divisor, fraction or mode takes effect at the next sample-period boundary. The period already in progress keeps its length.
- R8: Each strobe is registered and lasts one clock per event. The first sample strobe after loading a divisor of D (fraction 0, starting from IDLE) arrives D+1 clocks after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 low byte, 1 high byte, 2 fraction/mode) |
| wr_data | input | 8 | Register write data |
| ext_en | input | 1 | Enhanced-feature enable; gates writes to address 2 |
| sample_tick | output | 1 | One-clock strobe at the oversampling rate |
| bit_tick | output | 1 | One-clock strobe at the bit rate |

## Verification
The assertions assume the following about the inputs:
- `wr_addr` and `wr_data` are stable whenever `wr_en` is high.
- The enable input changes only between writes.
- Reset is held for at least one clock edge.

The bench drives every input on the falling edge, holds each write for exactly one clock, and changes `ext_en` only together with `wr_en`. A behavioural model of the period and bit timing, built from integer countdowns, is compared with both strobes on every clock. Targeted measurements of strobe spacing and of sample strobes per bit confirm the arithmetic independently of that model.

// File: rtl/baud_pkg.sv
package baud_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_STRETCH = 2'd2
    } gen_state_e;

    localparam logic [1:0] ADDR_DIV_LO = 2'd0;
    localparam logic [1:0] ADDR_DIV_HI = 2'd1;
    localparam logic [1:0] ADDR_FRAC   = 2'd2;

    // Sample strobes per bit strobe, minus one: 00 -> 16, 01 -> 8, 1x -> 4
    function automatic logic [3:0] ratio_m1(input logic [1:0] mode);
        logic [3:0] r;
        unique case (mode)
            2'b00:   r = 4'd15;
            2'b01:   r = 4'd7;
            default: r = 4'd3;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/baud_regs.sv
module baud_regs
    import baud_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int FRAC_W = 4,
    parameter int MODE_W = 2,
    localparam int DIV_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              ext_en,
    output logic [DIV_W-1:0]  div_q,
    output logic [FRAC_W-1:0] frac_q,
    output logic [MODE_W-1:0] mode_q
);

    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            frac_q <= '0;
            mode_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_DIV_LO: lo_q <= wr_data;
                ADDR_DIV_HI: hi_q <= wr_data;
                ADDR_FRAC: begin
                    if (ext_en) begin
                        frac_q <= wr_data[FRAC_W-1:0];
                        mode_q <= wr_data[FRAC_W +: MODE_W];
                    end
                end
                default: ;
            endcase
        end
    end

    assign div_q = {hi_q, lo_q};

    // R4: locked fraction register ignores writes
    assert_frac_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_FRAC && !ext_en) |=> ($stable(frac_q) && $stable(mode_q)));

endmodule

// File: rtl/baud_period.sv
module baud_period
    import baud_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  pend_div,
    input  logic [FRAC_W-1:0] pend_frac,
    input  logic [MODE_W-1:0] pend_mode,
    output logic              sample_tick,
    output logic              period_end,
    output logic              stopping,
    output logic [MODE_W-1:0] act_mode
);

    gen_state_e        state_q, state_d;
    logic [DIV_W-1:0]  cnt_q;
    logic [FRAC_W-1:0] acc_q;
    logic              stretch_q;
    logic [FRAC_W:0]   sum;
    logic              load;

    always_comb begin
        sum        = {1'b0, acc_q} + {1'b0, pend_frac};
        period_end = (state_q == ST_COUNT && cnt_q == '0 && !stretch_q)
                   || (state_q == ST_STRETCH);
        load       = (state_q == ST_IDLE || period_end) && (pend_div != '0);
        stopping   = period_end && (pend_div == '0);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (load) state_d = ST_COUNT;
            ST_COUNT: begin
                if (cnt_q == '0) begin
                    if (stretch_q)  state_d = ST_STRETCH;
                    else if (load)  state_d = ST_COUNT;
                    else            state_d = ST_IDLE;
                end
            end
            ST_STRETCH: state_d = load ? ST_COUNT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            acc_q     <= '0;
            stretch_q <= 1'b0;
            act_mode  <= '0;
            sample_tick <= 1'b0;
        end else begin
            sample_tick <= period_end;
            if (load) begin
                cnt_q     <= pend_div - 1'b1;
                stretch_q <= sum[FRAC_W];
                acc_q     <= sum[FRAC_W-1:0];
                act_mode  <= pend_mode;
            end else if (state_q == ST_COUNT && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (stopping) begin
                acc_q     <= '0;
                stretch_q <= 1'b0;
            end
        end
    end

    // R2: the stretch lasts a single clock
    assert_single_stretch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STRETCH) |=> (state_q != ST_STRETCH));

    // R7: settings loaded for a period hold until its boundary
    assert_mid_period_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && cnt_q != '0) |=> ($stable(act_mode) && $stable(stretch_q)));

    // R6: an idle generator stays quiet
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q == ST_IDLE)) |-> !sample_tick);

endmodule

// File: rtl/baud_bitdiv.sv
module baud_bitdiv
    import baud_pkg::*;
#(
    parameter int MODE_W = 2,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_end,
    input  logic              stopping,
    input  logic [MODE_W-1:0] mode,
    output logic              bit_tick
);

    logic [CNT_W-1:0] sc_q;
    logic             match;

    assign match = (sc_q >= ratio_m1(mode));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_q     <= '0;
            bit_tick <= 1'b0;
        end else begin
            bit_tick <= period_end && match;
            if (period_end) begin
                if (stopping || match) sc_q <= '0;
                else                   sc_q <= sc_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import baud_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int FRAC_W = 4,
    parameter int MODE_W = 2,
    localparam int DIV_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              ext_en,
    output logic              sample_tick,
    output logic              bit_tick
);

    logic [DIV_W-1:0]  div_w;
    logic [FRAC_W-1:0] frac_w;
    logic [MODE_W-1:0] mode_w;
    logic [MODE_W-1:0] act_mode_w;
    logic              period_end_w;
    logic              stopping_w;

    baud_regs #(.BYTE_W(BYTE_W), .FRAC_W(FRAC_W), .MODE_W(MODE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_en(ext_en),
        .div_q(div_w), .frac_q(frac_w), .mode_q(mode_w)
    );

    baud_period #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .MODE_W(MODE_W)) u_period (
        .clk(clk), .rst_n(rst_n), .pend_div(div_w), .pend_frac(frac_w),
        .pend_mode(mode_w), .sample_tick(sample_tick),
        .period_end(period_end_w), .stopping(stopping_w), .act_mode(act_mode_w)
    );

    baud_bitdiv #(.MODE_W(MODE_W), .CNT_W(4)) u_bitdiv (
        .clk(clk), .rst_n(rst_n), .period_end(period_end_w),
        .stopping(stopping_w), .mode(act_mode_w), .bit_tick(bit_tick)
    );

    // R3: bit strobe only with a sample strobe
    assert_bit_on_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);

endmodule

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ext_en = 1'b0;
    logic       sample_tick, bit_tick;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;
    string cur_req = "R6";

    always #2 clk = ~clk;

    frac_baud_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_en(ext_en),
        .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    // Behavioural reference: pending settings, countdown of the current period
    int p_div = 0, p_frac = 0, p_mode = 0;
    int busy = 0, left = 0, acc = 0, m_cur = 0, scnt = 0;
    bit exp_s = 0, exp_b = 0;

    function automatic int ratio_of(int m);
        if (m == 0) return 16;
        if (m == 1) return 8;
        return 4;
    endfunction

    task automatic m_start();
        int s;
        s = acc + p_frac;
        left = p_div + (s >= 16 ? 1 : 0);
        acc = s % 16;
        m_cur = p_mode;
        busy = 1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            p_div = 0; p_frac = 0; p_mode = 0;
            busy = 0; left = 0; acc = 0; m_cur = 0; scnt = 0;
            exp_s = 0; exp_b = 0;
        end else begin
            exp_s = 0; exp_b = 0;
            if (!busy) begin
                if (p_div != 0) m_start();
            end else begin
                left--;
                if (left == 0) begin
                    exp_s = 1;
                    if (scnt >= ratio_of(m_cur) - 1) begin exp_b = 1; scnt = 0; end
                    else scnt++;
                    if (p_div != 0) m_start();
                    else begin busy = 0; acc = 0; scnt = 0; end
                end
            end
            if (wr_en) begin
                if (wr_addr == 2'd0) p_div = (p_div & 32'hFF00) | int'(wr_data);
                else if (wr_addr == 2'd1) p_div = (p_div & 32'h00FF) | (int'(wr_data) << 8);
                else if (wr_addr == 2'd2 && ext_en) begin
                    p_frac = int'(wr_data[3:0]);
                    p_mode = int'(wr_data[5:4]);
                end
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Per-clock comparison against the model (R8 strobe shape included)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur_req, " sample_tick"}, int'(sample_tick), int'(exp_s));
            chk({cur_req, " bit_tick"}, int'(bit_tick), int'(exp_b));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic en);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; ext_en = en;
        @(negedge clk);
        wr_en = 1'b0; ext_en = 1'b0;
    endtask

    task automatic next_tick(output int t);
        do @(negedge clk); while (!sample_tick);
        t = cyc;
    endtask

    task automatic span(input int n, output int s);
        int t0, t1;
        next_tick(t0);
        t1 = t0;
        for (int i = 0; i < n; i++) next_tick(t1);
        s = t1 - t0;
    endtask

    task automatic per_bit(output int n);
        do @(negedge clk); while (!bit_tick);
        n = 0;
        do begin
            @(negedge clk);
            if (sample_tick) n++;
        end while (!bit_tick);
    endtask

    task automatic quiet(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sample_tick || bit_tick) cnt++;
        end
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int s, n, t0, t1;
        repeat (3) @(negedge clk);
        chk("R6 reset sample", int'(sample_tick), 0);
        chk("R6 reset bit", int'(bit_tick), 0);
        rst_n = 1'b1;
        quiet(40, n);
        chk("R6 quiet after reset", n, 0);

        // R8: first strobe latency from idle
        cur_req = "R8";
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd5; ext_en = 1'b0;
        t0 = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
        next_tick(t1);
        chk("R8 first strobe latency", t1 - t0, 6);

        // R1: integer divisor with high byte
        cur_req = "R1";
        span(4, s);
        chk("R1 low-byte spacing", s, 20);
        wr(2'd1, 8'd1, 1'b0);
        wr(2'd0, 8'd3, 1'b0);
        next_tick(t0);
        span(1, s);
        chk("R1 divisor 0x0103 spacing", s, 259);

        // R2: fractional dithering
        cur_req = "R2";
        wr(2'd1, 8'd0, 1'b0);
        wr(2'd2, 8'h05, 1'b1);
        span(2, s);
        span(16, s);
        chk("R2 sixteen periods D=3 F=5", s, 53);
        wr(2'd2, 8'h0B, 1'b1);
        span(2, s);
        span(16, s);
        chk("R2 sixteen periods D=3 F=11", s, 59);

        // R3: oversampling ratios
        cur_req = "R3";
        wr(2'd2, 8'h00, 1'b1);
        per_bit(n);
        per_bit(n);
        chk("R3 mode 00 ratio", n, 16);
        wr(2'd2, 8'h10, 1'b1);
        per_bit(n); per_bit(n);
        chk("R3 mode 01 ratio", n, 8);
        wr(2'd2, 8'h20, 1'b1);
        per_bit(n); per_bit(n);
        chk("R3 mode 10 ratio", n, 4);
        wr(2'd2, 8'h30, 1'b1);
        per_bit(n); per_bit(n);
        chk("R3 mode 11 ratio", n, 4);

        // R4: locked write ignored
        cur_req = "R4";
        wr(2'd0, 8'd4, 1'b0);
        wr(2'd2, 8'h0F, 1'b0);
        span(2, s);
        span(16, s);
        chk("R4 fraction unchanged", s, 64);
        per_bit(n); per_bit(n);
        chk("R4 mode unchanged", n, 4);

        // R5: reserved bits
        cur_req = "R5";
        wr(2'd2, 8'hC0, 1'b1);
        per_bit(n); per_bit(n);
        chk("R5 reserved bits ratio", n, 16);
        span(16, s);
        chk("R5 reserved bits spacing", s, 64);

        // R7: mid-period divisor change
        cur_req = "R7";
        wr(2'd0, 8'd20, 1'b0);
        span(2, s);
        next_tick(t0);
        repeat (3) @(negedge clk);
        wr(2'd0, 8'd6, 1'b0);
        next_tick(t1);
        chk("R7 current period kept", t1 - t0, 20);
        span(1, s);
        chk("R7 new period at boundary", s, 6);

        // R6: divisor zero stops, restart
        cur_req = "R6";
        wr(2'd0, 8'd0, 1'b0);
        repeat (10) @(negedge clk);
        quiet(200, n);
        chk("R6 zero divisor quiet", n, 0);
        wr(2'd2, 8'h28, 1'b1);
        wr(2'd0, 8'd2, 1'b0);
        span(16, s);
        chk("R6 restart D=2 F=8", s, 40);
        per_bit(n);
        chk("R6 restart ratio", n, 4);

        repeat (5) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule